// File: doc/BRIEF.md
# Exact-Latency Writeback Scheduler

This block is the result-return path of a datapath in which the latency of every operation is part of the program's meaning. Each issue slot hands over an operation with its destination register, its latency in cycles and its result value. The block keeps the operation in flight and lets it reach the register file only in the cycle its latency names. Until that cycle, any read of the destination returns the register's earlier contents. The scheduler does no dependence checking, renaming or interlocking, and it never stalls issue. Code scheduled with the latencies in mind relies on exactly that timing.

Each slot has a delay line whose stages carry a valid bit, a destination and a datum. An operation enters the stage that matches its latency and moves one stage toward the head on each clock. While it sits at the head, its slot's write port strobes. In that same cycle the read ports get the new value through a bypass. At the following edge the value is stored in the internal register file. A combinational error output flags schedules the hardware cannot honour. Two slots are provided, with latencies from 1 to 8, 32 registers of 32 bits and two read ports.

Top module: `exact_wb_sched`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, no write strobe is raised, the error output is low, and every register reads as zero.
- R2: An operation issued on slot s with latency L (1 to 8), sampled at a clock edge, raises write strobe bit s for exactly one cycle: the L-th cycle after that edge. It carries the operation's destination and data on slot s's write address and data ports, and it raises no strobe in the L-1 cycles before.
- R3: In the L-1 cycles between issue and completion, a read of the destination returns the value the register held before the operation was issued.
- R4: In the completion cycle, a read port addressed to the destination returns the new result by bypass. With latency 1, the very next cycle therefore already sees the result.
- R5: From the cycle after completion onward, the register file holds the result and read ports return it with no strobe active.
- R6: If both slots complete to the same register in the same cycle, only slot 1's strobe is raised, slot 1's value is bypassed and stored, and the error output is high in that cycle.
- R7: An issued latency of 0 or above 8 raises the error output combinationally in the issue cycle. The operation is dropped: no strobe follows, and the destination keeps its value.
- R8: If an operation is issued into a slot whose delay line already holds an operation due in the same completion cycle, the error output is high in the issue cycle. The new operation replaces the old one, which never writes its destination.
- R9: A slot accepts a new operation every cycle without stalling. Back-to-back operations of equal latency complete in consecutive cycles, in issue order.
- R10: Both slots may issue in the same cycle to different destinations, and both complete independently in their own latency cycles with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | SLOTS (2) | Per-slot issue strobe |
| issueDest | input | SLOTS x REG_W (2x5) | Per-slot destination register |
| issueLat | input | SLOTS x LAT_W (2x4) | Per-slot latency, valid range 1..8 |
| issueData | input | SLOTS x DATA_W (2x32) | Per-slot result value |
| rdAddr | input | RD_PORTS x REG_W (2x5) | Operand read addresses |
| rdData | output | RD_PORTS x DATA_W (2x32) | Operand values, bypassed in the completion cycle |
| wrEn | output | SLOTS (2) | Register-file write strobes |
| wrAddr | output | SLOTS x REG_W (2x5) | Register-file write addresses |
| wrData | output | SLOTS x DATA_W (2x32) | Register-file write data |
| schedErr | output | 1 | Schedule violation flag, combinational |

## Verification
Completion and reading can coincide: an operand read of a register in the very cycle that a delay line's head writes it must see the new value, never the stale one. The bench provokes this for every latency on both slots by holding a read port on the destination throughout the flight. It expects the old value up to the completion cycle and the new value from then on. A second overlap is two completions landing on one register in one cycle. This is arranged by issuing latency 3 on slot 0 and latency 1 on slot 1 two cycles apart, and it is judged by the strobes, the error flag and the value that survives.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;
  localparam int SLOTS    = 2;
  localparam int LAT_MAX  = 8;
  localparam int REGS     = 32;
  localparam int DATA_W   = 32;
  localparam int RD_PORTS = 2;
  localparam int REG_W    = $clog2(REGS);
  localparam int LAT_W    = $clog2(LAT_MAX + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic [SLOTS-1:0][LAT_MAX-1:0] load;    // stage to load with the issued op
    logic [SLOTS-1:0]              commit;  // head of slot writes this cycle
    logic                          schedErr;
  } wbCtrl_t;
endpackage

// File: rtl/wbs_lane.sv
`timescale 1ns/1ps
module wbs_lane
  import wbs_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [LAT_MAX-1:0]              load,
  input  logic [REG_W-1:0]                inDest,
  input  logic [DATA_W-1:0]               inData,
  output logic [LAT_MAX-1:0]              stageValid,
  output logic [REG_W-1:0]                headDest,
  output logic [DATA_W-1:0]               headData
);
  logic [LAT_MAX-1:0]             vld;
  logic [LAT_MAX-1:0][REG_W-1:0]  dst;
  logic [LAT_MAX-1:0][DATA_W-1:0] dat;
  logic [LAT_MAX-1:0]             shV;
  logic [LAT_MAX-1:0][REG_W-1:0]  shD;
  logic [LAT_MAX-1:0][DATA_W-1:0] shX;

  // Contents one stage closer to the head, empty at the tail
  always_comb begin
    shV = {1'b0, vld[LAT_MAX-1:1]};
    shD = {REG_W'(0), dst[LAT_MAX-1:1]};
    shX = {DATA_W'(0), dat[LAT_MAX-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
      dst <= '0;
      dat <= '0;
    end else begin
      for (int k = 0; k < LAT_MAX; k++) begin
        if (load[k]) begin
          vld[k] <= 1'b1;
          dst[k] <= inDest;
          dat[k] <= inData;
        end else begin
          vld[k] <= shV[k];
          dst[k] <= shD[k];
          dat[k] <= shX[k];
        end
      end
    end
  end

  assign stageValid = vld;
  assign headDest   = dst[0];
  assign headData   = dat[0];
endmodule

// File: rtl/wbs_ctrl.sv
`timescale 1ns/1ps
module wbs_ctrl
  import wbs_pkg::*;
(
  input  logic [SLOTS-1:0]              issueValid,
  input  logic [SLOTS-1:0][LAT_W-1:0]   issueLat,
  input  logic [SLOTS-1:0][LAT_MAX-1:0] stageValid,
  input  logic [SLOTS-1:0][REG_W-1:0]   headDest,
  output wbCtrl_t                       ctrl
);
  logic badLat;
  logic laneHit;
  logic clash;
  logic latOk;

  always_comb begin
    ctrl    = '0;
    badLat  = 1'b0;
    laneHit = 1'b0;
    clash   = 1'b0;
    latOk   = 1'b0;
    // Issue side: decode latency into a stage select
    for (int s = 0; s < SLOTS; s++) begin
      latOk = (issueLat[s] != '0) && (issueLat[s] <= LAT_W'(LAT_MAX));
      if (issueValid[s] && !latOk) badLat = 1'b1;
      if (issueValid[s] && latOk) begin
        for (int k = 0; k < LAT_MAX; k++) begin
          if (issueLat[s] == LAT_W'(k + 1)) ctrl.load[s][k] = 1'b1;
        end
        // Stage above the target moves into it at the same edge
        for (int k = 0; k < LAT_MAX - 1; k++) begin
          if (issueLat[s] == LAT_W'(k + 1) && stageValid[s][k+1]) laneHit = 1'b1;
        end
      end
    end
    // Completion side: higher slot wins a shared destination
    for (int s = 0; s < SLOTS; s++) begin
      ctrl.commit[s] = stageValid[s][0];
      for (int t = s + 1; t < SLOTS; t++) begin
        if (stageValid[s][0] && stageValid[t][0] && headDest[t] == headDest[s]) begin
          ctrl.commit[s] = 1'b0;
          clash          = 1'b1;
        end
      end
    end
    ctrl.schedErr = badLat | laneHit | clash;
  end
endmodule

// File: rtl/wbs_data.sv
`timescale 1ns/1ps
module wbs_data
  import wbs_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  wbCtrl_t                           ctrl,
  input  logic [SLOTS-1:0][REG_W-1:0]       issueDest,
  input  logic [SLOTS-1:0][DATA_W-1:0]      issueData,
  input  logic [RD_PORTS-1:0][REG_W-1:0]    rdAddr,
  output logic [RD_PORTS-1:0][DATA_W-1:0]   rdData,
  output logic [SLOTS-1:0][LAT_MAX-1:0]     stageValid,
  output logic [SLOTS-1:0][REG_W-1:0]       headDest,
  output logic [SLOTS-1:0][DATA_W-1:0]      headData
);
  logic [REGS-1:0][DATA_W-1:0] rf;

  for (genvar s = 0; s < SLOTS; s++) begin : gLane
    wbs_lane uLane (
      .clk        (clk),
      .rstN       (rstN),
      .load       (ctrl.load[s]),
      .inDest     (issueDest[s]),
      .inData     (issueData[s]),
      .stageValid (stageValid[s]),
      .headDest   (headDest[s]),
      .headData   (headData[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rf <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (ctrl.commit[s]) rf[headDest[s]] <= headData[s];
      end
    end
  end

  // Read with forwarding from completing heads, later slot last
  for (genvar r = 0; r < RD_PORTS; r++) begin : gRead
    always_comb begin
      rdData[r] = rf[rdAddr[r]];
      for (int s = 0; s < SLOTS; s++) begin
        if (ctrl.commit[s] && headDest[s] == rdAddr[r]) rdData[r] = headData[s];
      end
    end
  end
endmodule

// File: rtl/exact_wb_sched.sv
`timescale 1ns/1ps
module exact_wb_sched
  import wbs_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [SLOTS-1:0]                  issueValid,
  input  logic [SLOTS-1:0][REG_W-1:0]       issueDest,
  input  logic [SLOTS-1:0][LAT_W-1:0]       issueLat,
  input  logic [SLOTS-1:0][DATA_W-1:0]      issueData,
  input  logic [RD_PORTS-1:0][REG_W-1:0]    rdAddr,
  output logic [RD_PORTS-1:0][DATA_W-1:0]   rdData,
  output logic [SLOTS-1:0]                  wrEn,
  output logic [SLOTS-1:0][REG_W-1:0]       wrAddr,
  output logic [SLOTS-1:0][DATA_W-1:0]      wrData,
  output logic                              schedErr
);
  wbCtrl_t                       ctrl;
  logic [SLOTS-1:0][LAT_MAX-1:0] stageValid;
  logic [SLOTS-1:0][REG_W-1:0]   headDest;
  logic [SLOTS-1:0][DATA_W-1:0]  headData;

  wbs_ctrl uCtrl (
    .issueValid (issueValid),
    .issueLat   (issueLat),
    .stageValid (stageValid),
    .headDest   (headDest),
    .ctrl       (ctrl)
  );

  wbs_data uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .issueDest  (issueDest),
    .issueData  (issueData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .stageValid (stageValid),
    .headDest   (headDest),
    .headData   (headData)
  );

  assign wrEn     = ctrl.commit;
  assign wrAddr   = headDest;
  assign wrData   = headData;
  assign schedErr = ctrl.schedErr;
endmodule

// File: rtl/wbs_check.sv
`timescale 1ns/1ps
module wbs_check
  import wbs_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic [SLOTS-1:0]                  issueValid,
  input logic [SLOTS-1:0][LAT_W-1:0]       issueLat,
  input logic [REG_W-1:0]                  issueDestHi,
  input logic [DATA_W-1:0]                 issueDataHi,
  input logic [RD_PORTS-1:0][REG_W-1:0]    rdAddr,
  input logic [RD_PORTS-1:0][DATA_W-1:0]   rdData,
  input logic [SLOTS-1:0]                  wrEn,
  input logic [SLOTS-1:0][REG_W-1:0]       wrAddr,
  input logic [DATA_W-1:0]                 wrDataHi,
  input logic                              schedErr
);
  localparam int HI = SLOTS - 1;

  AST_LAT_ONE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    issueValid[HI] && issueLat[HI] == LAT_W'(1) |=> wrEn[HI] && wrAddr[HI] == $past(issueDestHi) && wrDataHi == $past(issueDataHi)); // R2

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    wrEn[0] && wrEn[HI] |-> wrAddr[0] != wrAddr[HI]); // R6

  AST_HOLD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn[HI]) && rdAddr[0] == $past(wrAddr[HI]) && !(wrEn[0] && wrAddr[0] == rdAddr[0]) && !(wrEn[HI] && wrAddr[HI] == rdAddr[0]) |-> rdData[0] == $past(wrDataHi)); // R5

  for (genvar r = 0; r < RD_PORTS; r++) begin : gBy
    AST_BYPASS_NEW: assert property (@(posedge clk) disable iff (!rstN)
      wrEn[HI] && wrAddr[HI] == rdAddr[r] |-> rdData[r] == wrDataHi); // R4
  end

  for (genvar s = 0; s < SLOTS; s++) begin : gLat
    AST_BAD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[s] && (issueLat[s] == '0 || issueLat[s] > LAT_W'(LAT_MAX)) |-> schedErr); // R7
  end
endmodule

bind exact_wb_sched wbs_check uChk (
  .clk         (clk),
  .rstN        (rstN),
  .issueValid  (issueValid),
  .issueLat    (issueLat),
  .issueDestHi (issueDest[wbs_pkg::SLOTS-1]),
  .issueDataHi (issueData[wbs_pkg::SLOTS-1]),
  .rdAddr      (rdAddr),
  .rdData      (rdData),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .wrDataHi    (wrData[wbs_pkg::SLOTS-1]),
  .schedErr    (schedErr)
);

// File: tb/sim_exact_wb_sched.sv
`timescale 1ns/1ps
module sim_exact_wb_sched;
  import wbs_pkg::*;

  logic clk = 1'b0;
  logic rstN;
  logic [SLOTS-1:0]                  issueValid;
  logic [SLOTS-1:0][REG_W-1:0]       issueDest;
  logic [SLOTS-1:0][LAT_W-1:0]       issueLat;
  logic [SLOTS-1:0][DATA_W-1:0]      issueData;
  logic [RD_PORTS-1:0][REG_W-1:0]    rdAddr;
  logic [RD_PORTS-1:0][DATA_W-1:0]   rdData;
  logic [SLOTS-1:0]                  wrEn;
  logic [SLOTS-1:0][REG_W-1:0]       wrAddr;
  logic [SLOTS-1:0][DATA_W-1:0]      wrData;
  logic                              schedErr;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exact_wb_sched u0 (
    .clk (clk), .rstN (rstN),
    .issueValid (issueValid), .issueDest (issueDest),
    .issueLat (issueLat), .issueData (issueData),
    .rdAddr (rdAddr), .rdData (rdData),
    .wrEn (wrEn), .wrAddr (wrAddr), .wrData (wrData),
    .schedErr (schedErr)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    issueValid = '0;
  endtask

  task automatic issue(input int s, input int lat, input int dest, input logic [DATA_W-1:0] d);
    issueValid[s] = 1'b1;
    issueLat[s]   = LAT_W'(lat);
    issueDest[s]  = REG_W'(dest);
    issueData[s]  = d;
  endtask

  task automatic preset(input int dest, input logic [DATA_W-1:0] d);
    idle();
    issue(0, 1, dest, d);
    tick();
    idle();
    tick();
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    idle();
    issueDest = '0; issueLat = '0; issueData = '0;
    rdAddr[0] = REG_W'(5); rdAddr[1] = REG_W'(31);
    repeat (3) tick();
    chk("R1 wrEn in reset", 64'(wrEn), 64'd0);
    chk("R1 schedErr in reset", 64'(schedErr), 64'd0);
    rstN = 1'b1;
    tick();
    chk("R1 wrEn after reset", 64'(wrEn), 64'd0);
    chk("R1 schedErr after reset", 64'(schedErr), 64'd0);
    chk("R1 reg5 zero", 64'(rdData[0]), 64'd0);
    chk("R1 reg31 zero", 64'(rdData[1]), 64'd0);
  endtask

  task automatic t_latency();
    for (int s = 0; s < SLOTS; s++) begin
      for (int lat = 1; lat <= LAT_MAX; lat++) begin
        int dest;
        logic [DATA_W-1:0] oldV, newV;
        dest = lat + s * 8;
        oldV = DATA_W'(32'h1000 + dest);
        newV = DATA_W'(32'hB000 + dest * 16 + lat);
        preset(dest, oldV);
        rdAddr[0] = REG_W'(dest);
        issue(s, lat, dest, newV);
        tick();
        idle();
        for (int c = 1; c < lat; c++) begin
          chk("R2 no early strobe", 64'(wrEn[s]), 64'd0);
          chk("R3 old value held", 64'(rdData[0]), 64'(oldV));
          tick();
        end
        chk("R2 strobe on time", 64'(wrEn[s]), 64'd1);
        chk("R2 write address", 64'(wrAddr[s]), 64'(dest));
        chk("R2 write data", 64'(wrData[s]), 64'(newV));
        chk("R4 bypass in completion cycle", 64'(rdData[0]), 64'(newV));
        tick();
        chk("R2 strobe one cycle", 64'(wrEn[s]), 64'd0);
        chk("R5 stored value", 64'(rdData[0]), 64'(newV));
      end
    end
  endtask

  task automatic t_backToBack();
    for (int cyc = 0; cyc < 8; cyc++) begin
      int k;
      if (cyc < 4) issue(0, 3, 10 + cyc, DATA_W'(32'h3000 + cyc));
      else idle();
      tick();
      k = cyc + 1 - 3;
      if (k >= 0 && k < 4) begin
        chk("R9 strobe", 64'(wrEn[0]), 64'd1);
        chk("R9 order address", 64'(wrAddr[0]), 64'(10 + k));
        chk("R9 order data", 64'(wrData[0]), 64'(32'h3000 + k));
      end else begin
        chk("R9 idle strobe", 64'(wrEn[0]), 64'd0);
      end
      chk("R9 no error", 64'(schedErr), 64'd0);
    end
    idle();
  endtask

  task automatic t_dual();
    rdAddr[0] = REG_W'(20); rdAddr[1] = REG_W'(21);
    issue(0, 2, 20, 32'hD0D0_0020);
    issue(1, 2, 21, 32'hD1D1_0021);
    tick();
    idle();
    chk("R10 no early strobes", 64'(wrEn), 64'd0);
    tick();
    chk("R10 both strobes", 64'(wrEn), 64'd3);
    chk("R10 slot0 value", 64'(rdData[0]), 64'h00000000D0D00020);
    chk("R10 slot1 value", 64'(rdData[1]), 64'h00000000D1D10021);
    chk("R10 no error", 64'(schedErr), 64'd0);
    tick();
  endtask

  task automatic t_conflict();
    preset(22, 32'h5555_0022);
    rdAddr[0] = REG_W'(22);
    issue(0, 3, 22, 32'hAAAA_0000);
    tick();
    idle();
    tick();
    issue(1, 1, 22, 32'hBBBB_0001);
    tick();
    idle();
    chk("R6 slot0 suppressed", 64'(wrEn[0]), 64'd0);
    chk("R6 slot1 writes", 64'(wrEn[1]), 64'd1);
    chk("R6 error flagged", 64'(schedErr), 64'd1);
    chk("R6 bypass winner", 64'(rdData[0]), 64'h00000000BBBB0001);
    tick();
    chk("R6 stored winner", 64'(rdData[0]), 64'h00000000BBBB0001);
    chk("R6 error clears", 64'(schedErr), 64'd0);
  endtask

  task automatic t_badLat();
    preset(23, 32'hC0C0_0023);
    rdAddr[0] = REG_W'(23);
    issue(0, 0, 23, 32'hDEAD_0000);
    #1;
    chk("R7 error on latency 0", 64'(schedErr), 64'd1);
    tick();
    issue(0, 9, 23, 32'hDEAD_0009);
    #1;
    chk("R7 error on latency 9", 64'(schedErr), 64'd1);
    tick();
    idle();
    for (int c = 0; c < 10; c++) begin
      chk("R7 no strobe", 64'(wrEn[0]), 64'd0);
      chk("R7 value kept", 64'(rdData[0]), 64'h00000000C0C00023);
      tick();
    end
  endtask

  task automatic t_lane();
    preset(24, 32'hE0E0_0024);
    preset(25, 32'hF0F0_0025);
    rdAddr[0] = REG_W'(24); rdAddr[1] = REG_W'(25);
    issue(0, 3, 24, 32'h6666_0024);
    tick();
    issue(0, 2, 25, 32'h7777_0025);
    #1;
    chk("R8 error on lane collision", 64'(schedErr), 64'd1);
    tick();
    idle();
    chk("R8 no strobe yet", 64'(wrEn[0]), 64'd0);
    tick();
    chk("R8 new op strobes", 64'(wrEn[0]), 64'd1);
    chk("R8 new op address", 64'(wrAddr[0]), 64'd25);
    chk("R8 new op data", 64'(wrData[0]), 64'h0000000077770025);
    tick();
    chk("R8 old op dropped", 64'(rdData[0]), 64'h00000000E0E00024);
    chk("R8 new value stored", 64'(rdData[1]), 64'h0000000077770025);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_backToBack();
    t_dual();
    t_conflict();
    t_badLat();
    t_lane();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule